// File: doc/BRIEF.md
# Streaming Configuration Host Transmitter

This block sits on the host side of a configuration link. It takes bitstream words from a local first-word-fall-through FIFO and pushes them into a target device over a one-way link made of a clock, a data bus and a valid flag. The target answers with a ready flag. That ready flag is asynchronous to the host, so the block resynchronizes it through a two-flop chain before any control logic uses it.

The link clock is the host clock passed straight through. It is never gated, so it keeps toggling while the host is stalled. A word leaves only when the synchronized ready is high, the FIFO is not empty and the programmed word count is not exhausted. The synchronizer delay means a few words still go out after the target drops ready. The block bounds that overshoot to three words, which is well under the six words the target tolerates. Software loads a word total with a one-cycle start pulse. A one-cycle done pulse marks the last word sent.

Top module: `cfgtx_host`

## Requirements
- R1: `link_clk` follows `clk` at all times, including reset, stalls and idle periods.
- R2: While `rst` is high at a rising edge, `link_vld`, `link_data`, `done` and both synchronizer stages clear to zero, and `src_rd` stays low afterwards until a transfer is started.
- R3: `link_vld` rises only if `link_rdy` was high at the clock edge three edges before the edge at which the rise is seen.
- R4: The sync path is two flops deep. If `link_rdy` is set high before edge E, with enough FIFO data and count remaining, the first valid word is registered at edge E+2.
- R5: After `link_rdy` falls, at most three words are exposed to the target with ready low: the word already on the bus and two words in flight. This stays within the target's six-word budget.
- R6: `link_data` carries the full `DATA_W` bits of each FIFO word. `DATA_W` is a build-time parameter of 8 or 16.
- R7: In a cycle where `src_empty` is high, `src_rd` stays low, `link_vld` goes low at the next edge and `link_data` keeps its previous value.
- R8: Each `src_rd` pulse registers the FIFO head word onto `link_data` with `link_vld` high at that same edge. Words leave in FIFO order.
- R9: A `start` pulse while idle loads `total_words`. After exactly that many words, `done` pulses high for one cycle and no further valid word is sent.
- R10: A `start` pulse during an active transfer is ignored and does not change the number of words sent.
- R11: While synchronized ready is low, sending pauses. It resumes with the next FIFO word once ready returns, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, also forwarded as link clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the word total when idle |
| total_words | input | CNT_W | Number of words to send for this transfer |
| src_data | input | DATA_W | Head word of the local FIFO |
| src_empty | input | 1 | FIFO has no word |
| src_rd | output | 1 | Pops the FIFO head word |
| link_clk | output | 1 | Free-running clock to the target |
| link_data | output | DATA_W | Data word to the target |
| link_vld | output | 1 | Marks a genuine word on `link_data` |
| link_rdy | input | 1 | Asynchronous ready from the target |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench looks hardest at what happens when ready falls while data is flowing. A design with a missing synchronizer stage or an extra pipeline register would expose fewer or more than three words, and the target-side count shows it. The bench also times the restart of valid after ready returns, so a one-flop or three-flop synchronizer shows up as valid one edge early or late. Empty cycles inside a burst catch a design that asserts valid on a stale word or lets the data bus drift. The short counted transfer catches an off-by-one total, a repeated done pulse, and a design that lets a second start reload the count while it is busy.

// File: rtl/cfgtx_pkg.sv
package cfgtx_pkg;
  // depth of the ready resynchronizer
  localparam int unsigned SYNC_DEPTH = 2;
  // words the target tolerates after ready falls
  localparam int unsigned TARGET_BUDGET = 6;
  // words this design can expose: bus word + sync depth
  localparam int unsigned OVERSHOOT_MAX = SYNC_DEPTH + 1;
endpackage

// File: rtl/cfgtx_sync.sv
module cfgtx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfgtx_count.sv
module cfgtx_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  input  logic             issue,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remaining;

  assign busy = (remaining != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= issue && (remaining == CNT_W'(1));
      if (start && !busy) remaining <= total;
      else if (issue)     remaining <= remaining - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cfgtx_out.sv
module cfgtx_out #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] link_data,
  output logic              link_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_data <= '0;
      link_vld  <= 1'b0;
    end else begin
      link_vld <= issue;
      if (issue) link_data <= word_in;
    end
  end
endmodule

// File: rtl/cfgtx_host.sv
module cfgtx_host
  import cfgtx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_words,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_empty,
  output logic              src_rd,
  output logic              link_clk,
  output logic [DATA_W-1:0] link_data,
  output logic              link_vld,
  input  logic              link_rdy,
  output logic              done
);
  logic rdy_sync;
  logic busy;
  logic issue;

  // forwarded clock, never gated
  assign link_clk = clk;

  cfgtx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (link_rdy),
    .sync_out (rdy_sync)
  );

  assign issue  = rdy_sync && !src_empty && busy;
  assign src_rd = issue;

  cfgtx_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .total (total_words),
    .issue (issue),
    .busy  (busy),
    .done  (done)
  );

  cfgtx_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .word_in   (src_data),
    .link_data (link_data),
    .link_vld  (link_vld)
  );
endmodule

// File: rtl/cfgtx_chk.sv
module cfgtx_chk
  import cfgtx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              src_empty,
  input logic              src_rd,
  input logic [DATA_W-1:0] link_data,
  input logic              link_vld,
  input logic              link_rdy,
  input logic              done
);
  // words seen by the target while its ready is low
  logic [3:0] exposed;

  always_ff @(posedge clk) begin
    if (rst || link_rdy) exposed <= '0;
    else if (link_vld && exposed != 4'hF) exposed <= exposed + 4'd1;
  end

  AST_VLD_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
    $rose(link_vld) |-> $past(link_rdy, 3)); // R3

  AST_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
    exposed <= 4'(OVERSHOOT_MAX)); // R5

  AST_BUDGET: assert property (@(posedge clk) disable iff (rst)
    exposed <= 4'(TARGET_BUDGET)); // R5

  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
    src_empty |-> !src_rd); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !link_vld |-> $stable(link_data)); // R7

  AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> link_vld); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
endmodule

bind cfgtx_host cfgtx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_empty (src_empty),
  .src_rd    (src_rd),
  .link_data (link_data),
  .link_vld  (link_vld),
  .link_rdy  (link_rdy),
  .done      (done)
);

// File: tb/sim_cfgtx_host.sv
`timescale 1ns/1ps
module sim_cfgtx_host;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int ROWS = 16;
  // each row: {ready, empty, expected valid}
  localparam logic [2:0] VEC [ROWS] = '{
    3'b100, 3'b100, 3'b101, 3'b110, 3'b101, 3'b001, 3'b001, 3'b000,
    3'b100, 3'b110, 3'b101, 3'b101, 3'b010, 3'b001, 3'b000, 3'b000
  };

  logic clk = 1'b0;
  logic rst, start, src_empty, src_rd, link_clk, link_vld, link_rdy, done;
  logic [CW-1:0] total_words;
  logic [DW-1:0] src_data, link_data;
  int rptr;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] word_at(int k);
    return DW'(16'h1F00 ^ (k * 16'h1357));
  endfunction

  assign src_data = word_at(rptr);
  always @(posedge clk) begin
    if (rst) rptr <= 0;
    else if (src_rd) rptr <= rptr + 1;
  end

  cfgtx_host #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .total_words(total_words),
    .src_data(src_data), .src_empty(src_empty), .src_rd(src_rd),
    .link_clk(link_clk), .link_data(link_data), .link_vld(link_vld),
    .link_rdy(link_rdy), .done(done)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; link_rdy = 1'b0; src_empty = 1'b1;
    total_words = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic kick(int n);
    start = 1'b1; total_words = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_errors++;
    $display("FAIL watchdog actual=1 expected=0");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] last;
    int widx;
    int exposed;
    int dones;
    int words;

    do_reset();
    // R2 reset state
    check(link_vld == 1'b0, "R2 vld", 32'(link_vld), 0);
    check(link_data == '0, "R2 data", 32'(link_data), 0);
    check(done == 1'b0 && src_rd == 1'b0, "R2 done/rd", {30'd0, done, src_rd}, 0);
    // R1 clock passthrough in both phases
    for (int i = 0; i < 4; i++) begin
      #1 check(link_clk == clk, "R1", 32'(link_clk), 32'(clk));
      #1;
    end
    @(negedge clk);

    // vector walk: R6 R7 R8 R11
    kick(1000);
    last = '0; widx = 0;
    for (int i = 0; i < ROWS; i++) begin
      link_rdy = VEC[i][2]; src_empty = VEC[i][1];
      #1 check(src_rd == VEC[i][0], "R8 rd", 32'(src_rd), 32'(VEC[i][0]));
      @(negedge clk);
      check(link_vld == VEC[i][0], "R11 vld", 32'(link_vld), 32'(VEC[i][0]));
      if (VEC[i][0]) begin
        last = word_at(widx); widx++;
        check(link_data == last, "R6 data", 32'(link_data), 32'(last));
      end else begin
        check(link_data == last, "R7 hold", 32'(link_data), 32'(last));
      end
    end

    // R4 resume latency, R5 overshoot
    do_reset();
    kick(1000);
    src_empty = 1'b0; link_rdy = 1'b1;
    @(negedge clk);
    check(link_vld == 1'b0, "R4 edge+0", 32'(link_vld), 0);
    @(negedge clk);
    check(link_vld == 1'b0, "R4 edge+1", 32'(link_vld), 0);
    @(negedge clk);
    check(link_vld == 1'b1, "R4 edge+2", 32'(link_vld), 1);
    repeat (3) @(negedge clk);
    exposed = 0;
    link_rdy = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      if (link_vld) exposed++;
      @(negedge clk);
    end
    check(exposed == 3, "R5 exposed", 32'(exposed), 3);
    check(exposed <= 6, "R5 budget", 32'(exposed), 6);

    // R9 R10 counted transfer
    do_reset();
    link_rdy = 1'b1; src_empty = 1'b0;
    repeat (3) @(negedge clk);
    kick(5);
    dones = 0; words = 0;
    for (int i = 0; i < 12; i++) begin
      start = (i == 1); total_words = CW'(50);
      @(negedge clk);
      if (link_vld) words++;
      if (done) begin
        dones++;
        check(words == 5, "R9 done timing", 32'(words), 5);
      end
    end
    start = 1'b0;
    check(words == 5, "R10 words", 32'(words), 5);
    check(dones == 1, "R9 pulses", 32'(dones), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule